// File: doc/BRIEF.md
# Serial Converter Word Receiver with Frame Abort

This block is the digital receive side of a three-wire serial write port that feeds a 14-bit voltage-output converter. An external host lowers an active-low frame-select line, clocks sixteen data bits in on falling serial-clock edges (most significant bit first), and the block turns each complete word into a held 14-bit code and a 2-bit output mode. The resistor string, the amplifier and the output switches live elsewhere. This block only produces the code and the control lines that pick how the output pin is driven or terminated.

All three serial pins are sampled through two-flop synchronizers into the system clock domain, and serial-clock edges are found there. The system clock must run at least four times faster than the serial clock. If a frame is cut short, because frame-select rises before the sixteenth falling edge, the partial word is thrown away and the held state does not change. A one-cycle strobe reports each accepted word and another reports each aborted one.

Top module: `sdac_frame_rx`

## Requirements
- R1: After reset the held code is 0, the mode is 00 (normal drive), and neither strobe is high.
- R2: A frame opens on a falling edge of frame-select. Each later falling edge of the serial clock shifts in one data bit, MSB first. In the 16-bit word, bits 15:14 are the mode and bits 13:0 are the code.
- R3: On the 16th falling edge the code and the mode are loaded together, and `word_ok` is high for exactly one system cycle. The held code and mode never change in any other cycle.
- R4: If frame-select rises after a frame opens but before its 16th falling edge, `word_abort` pulses for one cycle, and the code and mode keep their values. The partial bits are cleared, so the next full frame loads exactly its own 16 bits.
- R5: The mode is decoded so that exactly one of these four outputs is high: 00 gives `out_drive`, 01 gives `out_pull_1k`, 10 gives `out_pull_100k`, and 11 gives `out_hiz`.
- R6: A power-down mode leaves the code output holding the code bits of the word. A later word in normal mode with the same code bits restores normal drive at that code.
- R7: Falling serial-clock edges after the 16th are ignored while frame-select stays low. They neither shift data nor cause a second load or strobe.
- R8: When frame-select rises after a completed frame, there is no abort strobe. A new frame needs a new falling edge of frame-select.
- R9: `word_ok` and the new code and mode become visible after the third rising system-clock edge that follows the 16th serial-clock fall at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsel_n | input | 1 | Frame-select pin, active low, asynchronous |
| sclk_pin | input | 1 | Serial clock pin, asynchronous |
| sdata_pin | input | 1 | Serial data pin, asynchronous |
| code | output | 14 | Held converter code |
| mode | output | 2 | Held output mode field |
| out_drive | output | 1 | Amplifier drives the output (mode 00) |
| out_pull_1k | output | 1 | Output terminated by 1 kΩ to ground (mode 01) |
| out_pull_100k | output | 1 | Output terminated by 100 kΩ to ground (mode 10) |
| out_hiz | output | 1 | Output left floating (mode 11) |
| word_ok | output | 1 | One-cycle strobe: a word was accepted |
| word_abort | output | 1 | One-cycle strobe: a frame was aborted |

## Verification
A bit counter or shift register that is off by one shows up on the very next full word. The wrong code or mode, or a strobe on the wrong edge, appears three system cycles after the 16th serial fall. A counter that is not cleared on an abort corrupts the following word, so every abort length from 1 to 15 is followed by a full word that is checked. An enable that stays open after completion shows up as a second strobe, or a changed code, while extra clocks arrive under a still-low frame-select. A decode fault is visible at once on the four termination lines for every mode value.

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx #(
  parameter int FRAME_BITS = 16,
  parameter int CODE_W     = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsel_n,
  input  logic              sclk_pin,
  input  logic              sdata_pin,
  output logic [CODE_W-1:0] code,
  output logic [1:0]        mode,
  output logic              out_drive,
  output logic              out_pull_1k,
  output logic              out_pull_100k,
  output logic              out_hiz,
  output logic              word_ok,
  output logic              word_abort
);
  localparam int MODE_W = FRAME_BITS - CODE_W;
  localparam int CNT_W  = $clog2(FRAME_BITS);

  logic [1:0] fs_sy, ck_sy, dt_sy;
  logic       fs_d, ck_d;
  logic       open_q;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-2:0] shreg;
  logic [FRAME_BITS-1:0] word_nx;
  logic fs_s, ck_s, dt_s, fs_fall, fs_rise, ck_fall, last_bit;

  assign fs_s     = fs_sy[1];
  assign ck_s     = ck_sy[1];
  assign dt_s     = dt_sy[1];
  assign fs_fall  = fs_d & ~fs_s;
  assign fs_rise  = ~fs_d & fs_s;
  assign ck_fall  = ck_d & ~ck_s;
  assign last_bit = (cnt == CNT_W'(FRAME_BITS - 1));
  assign word_nx  = {shreg, dt_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_sy <= 2'b11;
      ck_sy <= 2'b00;
      dt_sy <= 2'b00;
      fs_d  <= 1'b1;
      ck_d  <= 1'b0;
    end else begin
      fs_sy <= {fs_sy[0], fsel_n};
      ck_sy <= {ck_sy[0], sclk_pin};
      dt_sy <= {dt_sy[0], sdata_pin};
      fs_d  <= fs_s;
      ck_d  <= ck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
      code       <= '0;
      mode       <= '0;
      word_ok    <= 1'b0;
      word_abort <= 1'b0;
    end else begin
      word_ok    <= 1'b0;
      word_abort <= 1'b0;
      if (fs_fall) begin
        open_q <= 1'b1;
        cnt    <= '0;
        shreg  <= '0;
      end else if (fs_rise) begin
        open_q     <= 1'b0;
        cnt        <= '0;
        shreg      <= '0;
        word_abort <= open_q;
      end else if (open_q && ck_fall) begin
        if (last_bit) begin
          code    <= word_nx[CODE_W-1:0];
          mode    <= word_nx[FRAME_BITS-1 -: MODE_W];
          word_ok <= 1'b1;
          open_q  <= 1'b0;
          cnt     <= '0;
          shreg   <= '0;
        end else begin
          shreg <= word_nx[FRAME_BITS-2:0];
          cnt   <= cnt + 1'b1;
        end
      end
    end
  end

  assign out_drive     = (mode == 2'b00);
  assign out_pull_1k   = (mode == 2'b01);
  assign out_pull_100k = (mode == 2'b10);
  assign out_hiz       = (mode == 2'b11);

  p_strobes_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_ok && word_abort));
  p_abort_holds_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_abort |-> ($stable(code) && $stable(mode)));
  p_state_moves_on_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(code) || !$stable(mode)) |-> word_ok);
  p_single_termination_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({out_drive, out_pull_1k, out_pull_100k, out_hiz}) == 1);
  p_ok_not_repeated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_ok |=> !word_ok);
  p_closed_after_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_ok |-> !open_q);
endmodule

// File: tb/sdac_frame_rx_bench.sv
module sdac_frame_rx_bench;
  logic clk = 0, rst_n = 0;
  logic fsel_n = 1, sclk_pin = 0, sdata_pin = 0;
  logic [13:0] code;
  logic [1:0]  mode;
  logic out_drive, out_pull_1k, out_pull_100k, out_hiz, word_ok, word_abort;
  int checks = 0, errors = 0, ok_cnt = 0, ab_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sdac_frame_rx u_sdac_frame_rx (
    .clk(clk), .rst_n(rst_n), .fsel_n(fsel_n), .sclk_pin(sclk_pin),
    .sdata_pin(sdata_pin), .code(code), .mode(mode), .out_drive(out_drive),
    .out_pull_1k(out_pull_1k), .out_pull_100k(out_pull_100k),
    .out_hiz(out_hiz), .word_ok(word_ok), .word_abort(word_abort));

  always @(negedge clk) begin
    if (word_ok) ok_cnt++;
    if (word_abort) ab_cnt++;
  end

  task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_state(input logic [15:0] w, input string req);
    logic [3:0] dec;
    dec = 4'b0001 << w[15:14];
    chk(code === w[13:0], req, code, w[13:0]);
    chk(mode === w[15:14], req, mode, w[15:14]);
    chk({out_hiz, out_pull_100k, out_pull_1k, out_drive} === dec, {req, " R5"},
        {out_hiz, out_pull_100k, out_pull_1k, out_drive}, dec);
  endtask

  // sends n bits, MSB of the n-bit field first; checks R9 timing on bit 16
  task automatic frame(input logic [31:0] bits, input int n, input bit release_fs);
    @(negedge clk); fsel_n = 0;
    waitc(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdata_pin = bits[i];
      sclk_pin = 1;
      waitc(4);
      sclk_pin = 0;
      if (i == n - 16) begin
        repeat (2) @(posedge clk);
        #1 chk(word_ok === 1'b0, "R9 early", word_ok, 0);
        @(posedge clk);
        #1 chk(word_ok === 1'b1, "R9", word_ok, 1);
        waitc(1);
      end else waitc(4);
    end
    if (release_fs) begin fsel_n = 1; waitc(6); end
  endtask

  initial begin
    logic [15:0] w, last;
    int o0, a0;
    waitc(3);
    #1 chk(code === 0 && mode === 0, "R1 code/mode", {mode, code}, 0);
    chk(out_drive === 1 && !word_ok && !word_abort, "R1 outputs",
        {out_drive, word_ok, word_abort}, 3'b100);
    @(negedge clk); rst_n = 1;
    waitc(4);
    check_state(16'h0000, "R1");

    // R2 R3 R5: sweep every mode with a spread of codes
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 8; k++) begin
        w = {m[1:0], 14'((k * 14'h0823 + m * 14'h1111) ^ (k[0] ? 14'h3FFF : 14'h0))};
        o0 = ok_cnt;
        frame({16'h0, w}, 16, 1);
        check_state(w, "R2 R3");
        chk(ok_cnt == o0 + 1, "R3 one strobe", ok_cnt - o0, 1);
        last = w;
      end
    end

    // R4: abort at every length, then a full frame after each
    for (int n = 1; n < 16; n++) begin
      o0 = ok_cnt; a0 = ab_cnt;
      frame(32'hFFFF_FFFF, n, 1);
      chk(ab_cnt == a0 + 1, "R4 abort strobe", ab_cnt - a0, 1);
      chk(ok_cnt == o0, "R4 no ok", ok_cnt - o0, 0);
      check_state(last, "R4 held");
      w = {2'(n), 14'(n * 14'h0411)};
      frame({16'h0, w}, 16, 1);
      check_state(w, "R4 next frame");
      last = w;
    end

    // R6: power-down keeps the code, return to normal restores it
    frame({16'h0, 2'b00, 14'h2ABC}, 16, 1);
    frame({16'h0, 2'b10, 14'h2ABC}, 16, 1);
    check_state({2'b10, 14'h2ABC}, "R6 power-down");
    frame({16'h0, 2'b00, 14'h2ABC}, 16, 1);
    check_state({2'b00, 14'h2ABC}, "R6 restore");

    // R7: extra clocks with frame-select still low
    o0 = ok_cnt; a0 = ab_cnt;
    frame({12'h0, 16'h4123, 4'hF}, 20, 0);
    chk(ok_cnt == o0 + 1, "R7 single strobe", ok_cnt - o0, 1);
    check_state(16'h4123, "R7");

    // R8: release after complete frame gives no abort
    fsel_n = 1; waitc(6);
    chk(ab_cnt == a0, "R8 no abort", ab_cnt - a0, 0);
    frame({16'h0, 16'hC001}, 16, 1);
    check_state(16'hC001, "R8 new frame");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule